// File: doc/BRIEF.md
# DMA Transfer Submission Register Bank

This block is the software-facing front end of a single-channel DMA engine. Software programs a staging set of descriptor registers: destination and source addresses, a row length and a row count (both stored minus one), and strides for two-dimensional moves. It also sets a cyclic-repeat flag and an end-of-transaction flag. Software then writes the start register. The bank stamps the descriptor with a rolling 5-bit transfer ID, places it in a queue of parameterized depth, and presents the queue head to the data-movement engine on a valid/ready handshake.

The engine reports each finished transfer by pulsing a completion strobe with that transfer's ID. The bank records completions in a 32-bit bitmap indexed by ID. It raises a start-of-transfer event when a descriptor enters the queue and an end-of-transfer event when a completion arrives. Both events are sticky and maskable, and software clears them by writing 1 to them. Build-time capabilities can be probed from software: an absent feature reads back as zero, and the row-length register reports its alignment granularity by forcing its low bits to one.

Top module: `dsr_top`

## Requirements
- R1: After reset the ID register reads 0, the mask register reads 3 (both sources masked), pending, done and start read 0, `irq` is low and the row-length register reads the alignment mask.
- R2: The ID register (word 0x101) returns the ID the next accepted descriptor receives. The ID advances by one modulo 32 on each acceptance and appears on `desc_id`.
- R3: Writing bit 0 = 1 to the start register (word 0x102) while enabled requests a submission. The request is accepted the following cycle if the queue has room, and it captures the staging fields. The start register reads 1 while a request waits.
- R4: Descriptors leave in acceptance order. The head stays stable while `desc_valid` is high and `desc_ready` is low.
- R5: Control bit 1 (pause) holds `desc_valid` low without discarding queued descriptors.
- R6: While control bit 0 (enable) is 0, the queue and any waiting request are discarded and start writes are ignored.
- R7: A completion sets done bit n for ID n (word 0x10A, read-only). Reissuing ID n clears that bit.
- R8: Pending bit 0 is set on each acceptance and pending bit 1 on each completion. Writing 1 to a pending bit clears it, but a same-cycle event keeps it set.
- R9: `irq` is high when any pending bit has its mask bit at 0. The source register (word 0x22) reads pending AND NOT mask.
- R10: The row-length register keeps its low ALIGN_BITS bits at 1 and bits at or above LEN_W at 0.
- R11: The flags register keeps bit 0 (cyclic) only with HAS_CYCLIC and bit 1 (last) always. The row-count register reads 0 without HAS_2D, and the address and stride registers of a side without memory access read 0.
- R12: The active-ID register (word 0x10B) and the current-address registers (source 0x10D, destination 0x10E) show the descriptor most recently taken by the engine.
- R13: The status register (word 0x10C) shows bit 0 = a request is waiting or the queue is non-empty, and bit 1 = queue full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 10 | Register word address (byte offset / 4) |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| desc_valid | output | 1 | Queue head is offered to the engine |
| desc_ready | input | 1 | Engine takes the head |
| desc_id | output | 5 | Transfer ID of the head |
| desc_dst | output | ADDR_W | Destination address |
| desc_src | output | ADDR_W | Source address |
| desc_xlen | output | LEN_W | Row length minus one |
| desc_ylen | output | LEN_W | Row count minus one |
| desc_dst_stride | output | LEN_W | Destination stride |
| desc_src_stride | output | LEN_W | Source stride |
| desc_cyclic | output | 1 | Repeat request |
| desc_last | output | 1 | Last segment of a software transaction |
| cpl_valid | input | 1 | Completion strobe |
| cpl_id | input | 5 | ID of the finished transfer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two copies on one register bus. The first uses the defaults: queue depth 2, 24-bit lengths, 3 alignment bits and every feature present. The small depth means two submissions fill the queue, so a third one reaches the waiting and full states. The second copy is built without cyclic mode, without 2D and without source memory access, so the zero read-back of absent features can be checked against the full copy. Thirty-two consecutive acceptances take the ID counter through its wrap, which exercises done-bit clearing on reissue.

// File: rtl/dsr_pkg.sv
// Shared constants for the DMA submission register bank.
// Assumes a 32-bit register port addressed by word.
package dsr_pkg;
    localparam int ID_W    = 5;
    localparam int NUM_IDS = 1 << ID_W;
    localparam int RA_W    = 10;

    // Register word addresses (byte offset / 4)
    localparam logic [RA_W-1:0] RA_IMASK   = 10'h020;
    localparam logic [RA_W-1:0] RA_IPEND   = 10'h021;
    localparam logic [RA_W-1:0] RA_ISRC    = 10'h022;
    localparam logic [RA_W-1:0] RA_CTRL    = 10'h100;
    localparam logic [RA_W-1:0] RA_NEXTID  = 10'h101;
    localparam logic [RA_W-1:0] RA_START   = 10'h102;
    localparam logic [RA_W-1:0] RA_FLAGS   = 10'h103;
    localparam logic [RA_W-1:0] RA_DST     = 10'h104;
    localparam logic [RA_W-1:0] RA_SRC     = 10'h105;
    localparam logic [RA_W-1:0] RA_XLEN    = 10'h106;
    localparam logic [RA_W-1:0] RA_YLEN    = 10'h107;
    localparam logic [RA_W-1:0] RA_DSTRIDE = 10'h108;
    localparam logic [RA_W-1:0] RA_SSTRIDE = 10'h109;
    localparam logic [RA_W-1:0] RA_DONE    = 10'h10A;
    localparam logic [RA_W-1:0] RA_ACTID   = 10'h10B;
    localparam logic [RA_W-1:0] RA_STATUS  = 10'h10C;
    localparam logic [RA_W-1:0] RA_CURSRC  = 10'h10D;
    localparam logic [RA_W-1:0] RA_CURDST  = 10'h10E;
endpackage

// File: rtl/dsr_fifo.sv
// Descriptor queue: DEPTH entries of DATA_W bits, head shown combinationally.
// Assumes the caller pushes only when not full and pops only when valid.
// Flush empties it in one cycle.
module dsr_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              full,
    input  logic              pop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];

    // Storage write on push
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R4
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> out_valid);
    // R4
    hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pop && !flush) |=> $stable(out_data));
endmodule

// File: rtl/dsr_idmap.sv
// Rolling transfer-ID counter and per-ID completion bitmap.
// A completion sets its bit; issuing an ID clears it, and completion wins a tie.
module dsr_idmap
    import dsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic               cpl_valid,
    input  logic [ID_W-1:0]    cpl_id,
    output logic [ID_W-1:0]    next_id,
    output logic [NUM_IDS-1:0] done
);
    // ID counter, wraps modulo NUM_IDS
    always_ff @(posedge clk) begin
        if (!rst_n)     next_id <= '0;
        else if (issue) next_id <= next_id + 1'b1;
    end

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_done
        // One done flag per ID
        always_ff @(posedge clk) begin
            if (!rst_n)
                done[i] <= 1'b0;
            else if (cpl_valid && cpl_id == ID_W'(i))
                done[i] <= 1'b1;
            else if (issue && next_id == ID_W'(i))
                done[i] <= 1'b0;
        end
    end

    // R2
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> next_id == ID_W'($past(next_id) + 1'b1));
    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> done[$past(cpl_id)]);
endmodule

// File: rtl/dsr_irq.sv
// Sticky interrupt sources with a mask. Writing 1 to a pending bit clears it,
// but an event in the same cycle keeps it set. Mask resets to all ones.
module dsr_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_wen,
    input  logic            pend_wen,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] evt,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] pend_q,
    output logic [NSRC-1:0] src,
    output logic            irq
);
    assign src = pend_q & ~mask_q;
    assign irq = |src;

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '1;
        else if (mask_wen) mask_q <= wdata;
    end

    // Pending bits: clear on write of 1, event has priority
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(pend_wen ? wdata : '0)) | evt;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R8
        evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> pend_q[i]);
    end
endmodule

// File: rtl/dsr_top.sv
// DMA transfer submission register bank: staging registers, ID stamping,
// descriptor queue, completion bitmap and interrupts.
// Assumes ADDR_W <= 32 and LEN_W <= 32. Reads have no side effects.
module dsr_top
    import dsr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24,
    parameter int ALIGN_BITS = 3,
    parameter int QDEPTH     = 2,
    parameter bit HAS_CYCLIC = 1'b1,
    parameter bit HAS_2D     = 1'b1,
    parameter bit DST_MM     = 1'b1,
    parameter bit SRC_MM     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [4:0]        desc_id,
    output logic [ADDR_W-1:0] desc_dst,
    output logic [ADDR_W-1:0] desc_src,
    output logic [LEN_W-1:0]  desc_xlen,
    output logic [LEN_W-1:0]  desc_ylen,
    output logic [LEN_W-1:0]  desc_dst_stride,
    output logic [LEN_W-1:0]  desc_src_stride,
    output logic              desc_cyclic,
    output logic              desc_last,
    input  logic              cpl_valid,
    input  logic [4:0]        cpl_id,
    output logic              irq
);
    localparam int DATA_W = ID_W + 2 * ADDR_W + 4 * LEN_W + 2;
    localparam logic [LEN_W-1:0] ALIGN_ONES = LEN_W'((1 << ALIGN_BITS) - 1);

    logic [1:0]        ctrl_q;
    logic              ctrl_en, ctrl_pause;
    logic [ADDR_W-1:0] dst_q, src_q, act_dst_q, act_src_q;
    logic [LEN_W-1:0]  xlen_q, ylen_q, dstride_q, sstride_q;
    logic              cyclic_q, last_q, sub_pend_q;
    logic [ID_W-1:0]   next_id, act_id_q;
    logic [NUM_IDS-1:0] done;
    logic              q_full, q_valid, push, pop;
    logic [DATA_W-1:0] q_in, q_out;
    logic [1:0]        mask_q, pend_q, src_bits;

    assign ctrl_en    = ctrl_q[0];
    assign ctrl_pause = ctrl_q[1];

    function automatic logic wr_hit(input logic [RA_W-1:0] a);
        return reg_wen && (reg_addr == a);
    endfunction

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)              ctrl_q <= '0;
        else if (wr_hit(RA_CTRL)) ctrl_q <= reg_wdata[1:0];
    end

    // Row length with forced alignment bits, and last flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlen_q <= ALIGN_ONES;
            last_q <= 1'b0;
        end else begin
            if (wr_hit(RA_XLEN))  xlen_q <= reg_wdata[LEN_W-1:0] | ALIGN_ONES;
            if (wr_hit(RA_FLAGS)) last_q <= reg_wdata[1];
        end
    end

    if (HAS_CYCLIC) begin : g_cyc
        // Cyclic flag storage
        always_ff @(posedge clk) begin
            if (!rst_n)               cyclic_q <= 1'b0;
            else if (wr_hit(RA_FLAGS)) cyclic_q <= reg_wdata[0];
        end
    end else begin : g_nocyc
        assign cyclic_q = 1'b0;
    end

    if (HAS_2D) begin : g_2d
        // Row count storage
        always_ff @(posedge clk) begin
            if (!rst_n)              ylen_q <= '0;
            else if (wr_hit(RA_YLEN)) ylen_q <= reg_wdata[LEN_W-1:0];
        end
    end else begin : g_no2d
        assign ylen_q = '0;
    end

    if (DST_MM) begin : g_dst
        // Destination address and stride storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dst_q     <= '0;
                dstride_q <= '0;
            end else begin
                if (wr_hit(RA_DST))     dst_q     <= reg_wdata[ADDR_W-1:0];
                if (wr_hit(RA_DSTRIDE)) dstride_q <= reg_wdata[LEN_W-1:0];
            end
        end
    end else begin : g_nodst
        assign dst_q     = '0;
        assign dstride_q = '0;
    end

    if (SRC_MM) begin : g_src
        // Source address and stride storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q     <= '0;
                sstride_q <= '0;
            end else begin
                if (wr_hit(RA_SRC))     src_q     <= reg_wdata[ADDR_W-1:0];
                if (wr_hit(RA_SSTRIDE)) sstride_q <= reg_wdata[LEN_W-1:0];
            end
        end
    end else begin : g_nosrc
        assign src_q     = '0;
        assign sstride_q = '0;
    end

    // Waiting submission request; dropped when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en) sub_pend_q <= 1'b0;
        else if (push)          sub_pend_q <= 1'b0;
        else if (wr_hit(RA_START) && reg_wdata[0]) sub_pend_q <= 1'b1;
    end

    assign push = sub_pend_q && !q_full && ctrl_en;
    assign q_in = {next_id, dst_q, src_q, xlen_q, ylen_q, dstride_q, sstride_q,
                   cyclic_q, last_q};

    dsr_fifo #(.DATA_W(DATA_W), .DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!ctrl_en),
        .push(push), .push_data(q_in), .full(q_full),
        .pop(pop), .out_valid(q_valid), .out_data(q_out)
    );

    assign desc_valid = q_valid && !ctrl_pause;
    assign pop        = desc_valid && desc_ready;
    assign {desc_id, desc_dst, desc_src, desc_xlen, desc_ylen, desc_dst_stride,
            desc_src_stride, desc_cyclic, desc_last} = q_out;

    // Record the descriptor the engine most recently took
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_id_q  <= '0;
            act_dst_q <= '0;
            act_src_q <= '0;
        end else if (pop) begin
            act_id_q  <= desc_id;
            act_dst_q <= desc_dst;
            act_src_q <= desc_src;
        end
    end

    dsr_idmap u_idmap (
        .clk(clk), .rst_n(rst_n), .issue(push),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .next_id(next_id), .done(done)
    );

    dsr_irq #(.NSRC(2)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .mask_wen(wr_hit(RA_IMASK)), .pend_wen(wr_hit(RA_IPEND)),
        .wdata(reg_wdata[1:0]), .evt({cpl_valid, push}),
        .mask_q(mask_q), .pend_q(pend_q), .src(src_bits), .irq(irq)
    );

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_IMASK:   reg_rdata = 32'(mask_q);
            RA_IPEND:   reg_rdata = 32'(pend_q);
            RA_ISRC:    reg_rdata = 32'(src_bits);
            RA_CTRL:    reg_rdata = 32'(ctrl_q);
            RA_NEXTID:  reg_rdata = 32'(next_id);
            RA_START:   reg_rdata = 32'(sub_pend_q);
            RA_FLAGS:   reg_rdata = 32'({last_q, cyclic_q});
            RA_DST:     reg_rdata = 32'(dst_q);
            RA_SRC:     reg_rdata = 32'(src_q);
            RA_XLEN:    reg_rdata = 32'(xlen_q);
            RA_YLEN:    reg_rdata = 32'(ylen_q);
            RA_DSTRIDE: reg_rdata = 32'(dstride_q);
            RA_SSTRIDE: reg_rdata = 32'(sstride_q);
            RA_DONE:    reg_rdata = 32'(done);
            RA_ACTID:   reg_rdata = 32'(act_id_q);
            RA_STATUS:  reg_rdata = 32'({q_full, sub_pend_q | q_valid});
            RA_CURSRC:  reg_rdata = 32'(act_src_q);
            RA_CURDST:  reg_rdata = 32'(act_dst_q);
            default:    reg_rdata = '0;
        endcase
    end

    // R6
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !desc_valid);
    // R12
    active_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> act_id_q == $past(desc_id));
endmodule

// File: tb/dsr_top_tb_top.sv
module dsr_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata, lite_rdata;
    logic        desc_valid, desc_ready = 1'b0;
    logic [4:0]  desc_id;
    logic [31:0] desc_dst, desc_src;
    logic [23:0] desc_xlen, desc_ylen, desc_dstr, desc_sstr;
    logic        desc_cyclic, desc_last;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_id = '0;
    logic        irq;
    logic        l_valid, l_cyc, l_last, l_irq;
    logic [4:0]  l_id;
    logic [31:0] l_dst, l_src;
    logic [23:0] l_x, l_y, l_ds, l_ss;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dsr_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(rdata),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_id(desc_id),
        .desc_dst(desc_dst), .desc_src(desc_src), .desc_xlen(desc_xlen),
        .desc_ylen(desc_ylen), .desc_dst_stride(desc_dstr),
        .desc_src_stride(desc_sstr), .desc_cyclic(desc_cyclic),
        .desc_last(desc_last), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .irq(irq)
    );

    dsr_top #(.HAS_CYCLIC(1'b0), .HAS_2D(1'b0), .SRC_MM(1'b0)) dut_lite_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(lite_rdata),
        .desc_valid(l_valid), .desc_ready(1'b0), .desc_id(l_id),
        .desc_dst(l_dst), .desc_src(l_src), .desc_xlen(l_x), .desc_ylen(l_y),
        .desc_dst_stride(l_ds), .desc_src_stride(l_ss), .desc_cyclic(l_cyc),
        .desc_last(l_last), .cpl_valid(1'b0), .cpl_id(5'd0), .irq(l_irq)
    );

    typedef struct packed {
        logic [9:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_full;
        logic [31:0] exp_lite;
        logic [7:0]  req;
    } vec_t;

    // R10 length alignment, R11 capability read-back, R9 mask, R13/R7 read-only
    localparam vec_t VECS [12] = '{
        '{10'h106, 32'h0000_0000, 32'h0000_0007, 32'h0000_0007, 8'd10},
        '{10'h106, 32'h0001_2340, 32'h0001_2347, 32'h0001_2347, 8'd10},
        '{10'h106, 32'hFFFF_FFFF, 32'h00FF_FFFF, 32'h00FF_FFFF, 8'd10},
        '{10'h107, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 8'd11},
        '{10'h103, 32'h0000_0003, 32'h0000_0003, 32'h0000_0002, 8'd11},
        '{10'h105, 32'hCAFE_0000, 32'hCAFE_0000, 32'h0000_0000, 8'd11},
        '{10'h109, 32'h0000_0040, 32'h0000_0040, 32'h0000_0000, 8'd11},
        '{10'h104, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 8'd11},
        '{10'h108, 32'h0000_0080, 32'h0000_0080, 32'h0000_0080, 8'd11},
        '{10'h020, 32'h0000_0002, 32'h0000_0002, 32'h0000_0002, 8'd9},
        '{10'h10C, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0000, 8'd13},
        '{10'h10A, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 8'd7}
    };

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic submit();
        wr(10'h102, 32'h1);
        step(1);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        logic [31:0] v;
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(10'h101, v); check("R1 next id", v, 0);
        rd(10'h020, v); check("R1 mask", v, 3);
        rd(10'h021, v); check("R1 pending", v, 0);
        rd(10'h10A, v); check("R1 done", v, 0);
        rd(10'h102, v); check("R1 start", v, 0);
        rd(10'h106, v); check("R1 xlen", v, 7);
        check("R1 irq", 32'(irq), 0);

        foreach (VECS[i]) begin
            wr(VECS[i].addr, VECS[i].wdata);
            rd(VECS[i].addr, v);
            check($sformatf("R%0d full vec %0d", VECS[i].req, i), v, VECS[i].exp_full);
            #1;
            check($sformatf("R%0d lite vec %0d", VECS[i].req, i), lite_rdata,
                  VECS[i].exp_lite);
        end

        // R3 first submission captures staging fields
        wr(10'h100, 32'h1);
        wr(10'h020, 32'h0);
        wr(10'h104, 32'h1000);
        wr(10'h105, 32'h2000);
        wr(10'h106, 32'h3F);
        wr(10'h103, 32'h2);
        wr(10'h102, 32'h1);
        rd(10'h102, v); check("R3 start waiting", v, 1);
        step(1);
        check("R3 valid", 32'(desc_valid), 1);
        check("R2 desc id 0", 32'(desc_id), 0);
        check("R3 dst", desc_dst, 32'h1000);
        check("R3 src", desc_src, 32'h2000);
        check("R3 xlen", 32'(desc_xlen), 32'h3F);
        check("R3 last/cyclic", 32'({desc_last, desc_cyclic}), 2);
        rd(10'h101, v); check("R2 next id 1", v, 1);
        rd(10'h021, v); check("R8 sot pending", v, 1);
        check("R9 irq on sot", 32'(irq), 1);
        rd(10'h10C, v); check("R13 busy", v, 1);

        // R9 masking
        wr(10'h020, 32'h1);
        check("R9 irq masked", 32'(irq), 0);
        rd(10'h022, v); check("R9 source masked", v, 0);
        rd(10'h021, v); check("R9 pending kept", v, 1);
        wr(10'h020, 32'h0);
        rd(10'h022, v); check("R9 source unmasked", v, 1);

        // R3 fill queue, third request waits
        wr(10'h104, 32'h1100);
        submit();
        wr(10'h104, 32'h1200);
        wr(10'h102, 32'h1);
        step(3);
        rd(10'h102, v); check("R3 start blocked", v, 1);
        rd(10'h10C, v); check("R13 busy+full", v, 3);
        rd(10'h101, v); check("R2 next id 2", v, 2);
        check("R4 head stable", desc_dst, 32'h1000);

        // R8 clear by write of one
        wr(10'h021, 32'h1);
        rd(10'h021, v); check("R8 cleared", v, 0);
        check("R8 irq low", 32'(irq), 0);

        // R4 pop one, R12 active
        desc_ready = 1'b1;
        step(1);
        desc_ready = 1'b0;
        check("R4 order id1", 32'(desc_id), 1);
        rd(10'h10B, v); check("R12 active id", v, 0);
        rd(10'h10E, v); check("R12 cur dst", v, 32'h1000);
        rd(10'h10D, v); check("R12 cur src", v, 32'h2000);
        step(1);
        rd(10'h102, v); check("R3 start accepted", v, 0);
        rd(10'h101, v); check("R2 next id 3", v, 3);

        // R5 pause
        wr(10'h100, 32'h3);
        check("R5 paused", 32'(desc_valid), 0);
        rd(10'h10C, v); check("R5 still queued", v[0], 1);
        wr(10'h100, 32'h1);
        check("R5 resumed", 32'(desc_valid), 1);
        check("R5 nothing lost", 32'(desc_id), 1);

        // R7 completion, R8 simultaneous clear and event
        cpl_id = 5'd0; cpl_valid = 1'b1;
        step(1);
        cpl_valid = 1'b0;
        rd(10'h10A, v); check("R7 done bit0", v, 1);
        rd(10'h021, v); check("R8 eot pending", v, 3);
        cpl_id = 5'd1; cpl_valid = 1'b1;
        wr(10'h021, 32'h3);
        cpl_valid = 1'b0;
        rd(10'h021, v); check("R8 event beats clear", v, 2);
        rd(10'h10A, v); check("R7 done bits", v, 3);

        // R2 wrap through 32 IDs, R7 clear on reissue
        desc_ready = 1'b1;
        for (int k = 3; k < 32; k++) submit();
        step(2);
        rd(10'h101, v); check("R2 wrap to 0", v, 0);
        rd(10'h10A, v); check("R7 before reissue", v, 3);
        submit();
        step(1);
        rd(10'h10A, v); check("R7 reissue clears", v, 2);
        rd(10'h10B, v); check("R12 active after wrap", v, 0);
        desc_ready = 1'b0;

        // R6 disable discards
        submit();
        submit();
        check("R6 queued before", 32'(desc_valid), 1);
        wr(10'h100, 32'h0);
        step(1);
        check("R6 flushed", 32'(desc_valid), 0);
        rd(10'h10C, v); check("R6 status idle", v, 0);
        wr(10'h102, 32'h1);
        step(1);
        rd(10'h102, v); check("R6 start ignored", v, 0);
        rd(10'h101, v); check("R6 id unchanged", v, 3);
        wr(10'h100, 32'h1);
        step(1);
        check("R6 empty after enable", 32'(desc_valid), 0);

        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end
endmodule